// File: doc/BRIEF.md
# Sequence-Ordered Memory Disambiguation Table

This block finds memory ordering mistakes in an out-of-order core without searching a load queue. It is a direct-mapped table indexed by the low address bits. Each entry keeps, for one in-flight address, the youngest load sequence number and the youngest store sequence number that have executed to it so far.

Every executing load or store presents its address, sequence number and kind on the access port. The table compares that sequence number with the recorded maximums. It reports a true, anti or output dependence violation with a combined recovery request, or a replay request when the indexed slot belongs to another address. It then raises the maximums.

Retiring instructions free their entry once nothing younger is recorded there. A flush empties the whole table. The flush and the recovery themselves are handled elsewhere.

Top module: `seqnum_disamb_table`

## Requirements
- R1: After reset all result outputs are low and the table is empty: the first access to any address allocates a slot and reports neither violation nor replay.
- R2: Each access accepted with `flush` low produces exactly one result on the cycle after it (`res_valid` high), and `res_valid` is low on a cycle with no accepted access, with every flag low.
- R3: The slot is selected by the low `IDX_BITS` address bits and the tag is the remaining upper bits. An access whose slot holds another tag gets `res_replay` high with no violation flag, and the table is left unchanged.
- R4: A store whose sequence number is older than the recorded load maximum of its address raises `res_true` and `res_recover`.
- R5: A store older than the recorded store maximum of its address raises `res_out` and `res_recover`.
- R6: A load older than the recorded store maximum of its address raises `res_anti` and `res_recover`.
- R7: After its checks, a hitting access sets the maximum of its own kind to the younger of the old value and its sequence number. An older access never lowers a maximum.
- R8: Sequence numbers are `SEQ_W+1` bits wide, and a is older than b when bit `SEQ_W` of (a − b) modulo 2^(SEQ_W+1) is set. Ordering therefore holds across the wrap of the counter.
- R9: A retire on a hitting slot frees it when the retiring sequence number equals one of the recorded maximums and neither recorded maximum is younger than it. Otherwise the slot stays.
- R10: `flush` empties the table, and an access presented in the same cycle is dropped with no result.
- R11: A load never raises `res_true` or `res_out`, a store never raises `res_anti`, and an older load never raises anything because of the load maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empties the table, drops the same-cycle access |
| acc_valid | input | 1 | An access is presented |
| acc_is_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Access address |
| acc_seq | input | SEQ_W+1 | Access sequence number |
| ret_valid | input | 1 | A retire is presented |
| ret_addr | input | ADDR_W | Retiring address |
| ret_seq | input | SEQ_W+1 | Retiring sequence number |
| res_valid | output | 1 | Result for the previous cycle's access |
| res_replay | output | 1 | Slot conflict, re-execute the access |
| res_true | output | 1 | True-dependence violation |
| res_anti | output | 1 | Anti-dependence violation |
| res_out | output | 1 | Output-dependence violation |
| res_recover | output | 1 | Recovery request, any violation |

## Verification
The bench builds the table with `ADDR_W=8`, `IDX_BITS=2` and `SEQ_W=3`. Four slots let two nearby addresses collide, so replays, blocked slots and slots freed by retire are reached in a few accesses. Four-bit sequence numbers wrap after sixteen, so a short vector walk crosses the wrap and tests the modular ordering in every violation kind.

// File: rtl/seqnum_disamb_table.sv
module seqnum_disamb_table #(
  parameter int ADDR_W   = 32,
  parameter int IDX_BITS = 4,
  parameter int SEQ_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              acc_valid,
  input  logic              acc_is_store,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SEQ_W:0]    acc_seq,
  input  logic              ret_valid,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [SEQ_W:0]    ret_seq,
  output logic              res_valid,
  output logic              res_replay,
  output logic              res_true,
  output logic              res_anti,
  output logic              res_out,
  output logic              res_recover
);
  localparam int ENTRIES = 1 << IDX_BITS;
  localparam int TAG_W   = ADDR_W - IDX_BITS;
  localparam int SN_W    = SEQ_W + 1;

  logic [ENTRIES-1:0] vld, ld_seen, st_seen;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [SN_W-1:0]    ld_max [ENTRIES];
  logic [SN_W-1:0]    st_max [ENTRIES];

  // a older than b, modular over SN_W bits
  function automatic logic older(input logic [SN_W-1:0] a, input logic [SN_W-1:0] b);
    logic [SN_W-1:0] d;
    d = a - b;
    return d[SN_W-1];
  endfunction

  logic [IDX_BITS-1:0] a_idx, r_idx;
  logic [TAG_W-1:0]    a_tag, r_tag;
  logic a_go, a_hit, a_conf;
  logic chk_true, chk_out, chk_anti, ld_take, st_take;
  logic r_hit, r_ld_eq, r_st_eq, r_ld_young, r_st_young, r_free;

  assign a_idx  = acc_addr[IDX_BITS-1:0];
  assign a_tag  = acc_addr[ADDR_W-1:IDX_BITS];
  assign a_go   = acc_valid && !flush;
  assign a_hit  = vld[a_idx] && (tag_q[a_idx] == a_tag);
  assign a_conf = vld[a_idx] && !a_hit;

  assign chk_true = acc_is_store  && a_hit && ld_seen[a_idx] && older(acc_seq, ld_max[a_idx]);
  assign chk_out  = acc_is_store  && a_hit && st_seen[a_idx] && older(acc_seq, st_max[a_idx]);
  assign chk_anti = !acc_is_store && a_hit && st_seen[a_idx] && older(acc_seq, st_max[a_idx]);

  assign ld_take = !acc_is_store &&
                   (!a_hit || !ld_seen[a_idx] || older(ld_max[a_idx], acc_seq));
  assign st_take = acc_is_store &&
                   (!a_hit || !st_seen[a_idx] || older(st_max[a_idx], acc_seq));

  assign r_idx      = ret_addr[IDX_BITS-1:0];
  assign r_tag      = ret_addr[ADDR_W-1:IDX_BITS];
  assign r_hit      = vld[r_idx] && (tag_q[r_idx] == r_tag);
  assign r_ld_eq    = ld_seen[r_idx] && (ld_max[r_idx] == ret_seq);
  assign r_st_eq    = st_seen[r_idx] && (st_max[r_idx] == ret_seq);
  assign r_ld_young = ld_seen[r_idx] && older(ret_seq, ld_max[r_idx]);
  assign r_st_young = st_seen[r_idx] && older(ret_seq, st_max[r_idx]);
  assign r_free     = ret_valid && r_hit && (r_ld_eq || r_st_eq) &&
                      !r_ld_young && !r_st_young && !(a_go && a_idx == r_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld         <= '0;
      ld_seen     <= '0;
      st_seen     <= '0;
      res_valid   <= 1'b0;
      res_replay  <= 1'b0;
      res_true    <= 1'b0;
      res_anti    <= 1'b0;
      res_out     <= 1'b0;
      res_recover <= 1'b0;
    end else begin
      res_valid   <= a_go;
      res_replay  <= a_go && a_conf;
      res_true    <= a_go && chk_true;
      res_anti    <= a_go && chk_anti;
      res_out     <= a_go && chk_out;
      res_recover <= a_go && (chk_true || chk_anti || chk_out);
      if (flush) begin
        vld     <= '0;
        ld_seen <= '0;
        st_seen <= '0;
      end else begin
        if (r_free) begin
          vld[r_idx]     <= 1'b0;
          ld_seen[r_idx] <= 1'b0;
          st_seen[r_idx] <= 1'b0;
        end
        if (a_go && !a_conf) begin
          vld[a_idx] <= 1'b1;
          if (!a_hit) begin
            ld_seen[a_idx] <= !acc_is_store;
            st_seen[a_idx] <= acc_is_store;
          end else if (acc_is_store) begin
            st_seen[a_idx] <= 1'b1;
          end else begin
            ld_seen[a_idx] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (a_go && !a_conf) begin
      tag_q[a_idx] <= a_tag;
      if (ld_take) ld_max[a_idx] <= acc_seq;
      if (st_take) st_max[a_idx] <= acc_seq;
    end
  end
endmodule

// File: rtl/seqnum_disamb_table_chk.sv
module seqnum_disamb_table_chk (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic acc_valid,
  input logic acc_is_store,
  input logic res_valid,
  input logic res_replay,
  input logic res_true,
  input logic res_anti,
  input logic res_out,
  input logic res_recover
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_replay || res_true || res_anti || res_out || res_recover));

  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !flush) |=> res_valid);

  assert_flush_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !res_valid);

  assert_replay_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_replay |-> !(res_true || res_anti || res_out || res_recover));

  assert_load_kinds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_is_store) |=> !(res_true || res_out));

  assert_store_kinds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_is_store) |=> !res_anti);
endmodule

bind seqnum_disamb_table seqnum_disamb_table_chk u_chk (.*);

// File: tb/seqnum_disamb_table_test.sv
module seqnum_disamb_table_test;
  localparam int AW = 8;
  localparam int IB = 2;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic acc_valid = 1'b0, acc_is_store = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [SW:0]   acc_seq = '0;
  logic ret_valid = 1'b0;
  logic [AW-1:0] ret_addr = '0;
  logic [SW:0]   ret_seq = '0;
  logic res_valid, res_replay, res_true, res_anti, res_out, res_recover;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  seqnum_disamb_table #(.ADDR_W(AW), .IDX_BITS(IB), .SEQ_W(SW)) uut (.*);

  // {store, addr, seq, replay, true, anti, out}
  localparam logic [16:0] VEC [17] = '{
    {1'b0, 8'h10, 4'd3,  4'b0000},  // R1 allocate
    {1'b1, 8'h10, 4'd2,  4'b0100},  // R4
    {1'b1, 8'h10, 4'd1,  4'b0101},  // R4 R5
    {1'b0, 8'h10, 4'd1,  4'b0010},  // R6
    {1'b1, 8'h10, 4'd4,  4'b0000},  // R7
    {1'b0, 8'h10, 4'd2,  4'b0010},  // R6
    {1'b1, 8'h10, 4'd3,  4'b0001},  // R5 R11
    {1'b1, 8'h10, 4'd2,  4'b0101},  // R7 load max kept
    {1'b0, 8'h14, 4'd5,  4'b1000},  // R3 conflict
    {1'b0, 8'h11, 4'd5,  4'b0000},  // R3 other slot
    {1'b1, 8'h11, 4'd6,  4'b0000},
    {1'b0, 8'h11, 4'd5,  4'b0010},  // R6
    {1'b1, 8'h12, 4'd14, 4'b0000},  // R8
    {1'b0, 8'h12, 4'd1,  4'b0000},  // R8 wrap younger
    {1'b1, 8'h12, 4'd15, 4'b0100},  // R8 R4
    {1'b1, 8'h12, 4'd0,  4'b0100},  // R8 R7
    {1'b0, 8'h12, 4'd15, 4'b0010}   // R8 R6
  };

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %b expected %b (valid,replay,true,anti,out,recover)", req, got, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {res_valid, res_replay, res_true, res_anti, res_out, res_recover};
  endfunction

  task automatic access(input logic st, input logic [AW-1:0] a, input logic [SW:0] s);
    acc_valid = 1'b1; acc_is_store = st; acc_addr = a; acc_seq = s;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic retire(input logic [AW-1:0] a, input logic [SW:0] s);
    ret_valid = 1'b1; ret_addr = a; ret_seq = s;
    @(posedge clk); @(negedge clk);
    ret_valid = 1'b0;
  endtask

  function automatic logic [5:0] expect_of(input logic [3:0] f);
    return {1'b1, f, |f[2:0]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", outs(), 6'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle", outs(), 6'b0);

    for (int i = 0; i < 17; i++) begin
      access(VEC[i][16], VEC[i][15:8], VEC[i][7:4]);
      check($sformatf("R3-R8 vector %0d", i), outs(), expect_of(VEC[i][3:0]));
    end

    @(negedge clk);
    check("R2 no access no result", outs(), 6'b0);

    // slot 1 holds 0x11 with load max 5, store max 6
    retire(8'h11, 4'd5);
    access(1'b0, 8'h15, 4'd7);
    check("R9 older retire keeps slot", outs(), expect_of(4'b1000));
    retire(8'h11, 4'd6);
    access(1'b0, 8'h15, 4'd7);
    check("R9 youngest retire frees slot", outs(), expect_of(4'b0000));

    // R10: flush with a same-cycle access
    flush = 1'b1;
    access(1'b1, 8'h16, 4'd2);
    flush = 1'b0;
    check("R10 access dropped in flush", outs(), 6'b0);
    access(1'b0, 8'h14, 4'd9);
    check("R10 table empty after flush", outs(), expect_of(4'b0000));
    access(1'b1, 8'h16, 4'd0);
    check("R10 dropped store left no entry", outs(), expect_of(4'b0000));
    access(1'b0, 8'h16, 4'd0);
    check("R11 equal load no violation", outs(), expect_of(4'b0000));
    access(1'b0, 8'h16, 4'd15);
    check("R11 older load ignores load max", outs(), expect_of(4'b0010));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule